// File: doc/BRIEF.md
# Pause Frame Flow Control Generator

This block sits beside the transmit path of a full-duplex Ethernet MAC. It decides when a flow-control pause frame has to go out and produces that frame as a byte stream. The stream is 60 bytes long: destination 01-80-C2-00-00-01, the station source address, type 0x8808, opcode 0x0001, a 16-bit pause time, and zero padding. The downstream transmitter appends the FCS. Bytes leave over a valid/ready handshake. A new frame starts only when the MAC transmitter is not already busy with another frame.

There are two triggers. Software can raise a one-shot request. The request flag stays visible until the frame has been handed over in full, and then it clears itself. The receive FIFO can also report that it is full. In that case the block advertises the programmed pause time. It then counts the remote pause down in 512-bit-time quanta, using a tick that the MAC supplies. When the count reaches a programmable low threshold, the block samples the FIFO. If the FIFO is still full, it sends a fresh pause. If the FIFO has drained, it sends a zero-time pause, which lets the remote end resume.

Top module: `pause_fc_gen`

## Requirements
- R1: While `fc_en_i` or `full_duplex_i` is low, no frame starts. A software request pulse given in that state is dropped, and `sw_req_busy_o` stays 0.
- R2: A pulse on `sw_req_set_i` makes `sw_req_busy_o` read 1 from the next cycle on. Exactly one frame follows, carrying `pause_time_i`. `sw_req_busy_o` returns to 0 once the last byte of that frame is accepted.
- R3: Every frame has exactly 60 bytes. Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are `src_addr_i`, bits 47:40 first. Bytes 12-15 are 88 08 00 01. Byte 16 is the pause time high byte and byte 17 the low byte. Bytes 18-59 are 00. `tx_last_o` is high on byte 59 only.
- R4: When `rx_full_i` is high and no FIFO-driven pause is being advertised, a frame carrying `pause_time_i` is sent.
- R5: After each frame, the remaining quanta are loaded from the time that frame carried. Each `quanta_tick_i` pulse takes one away. Once the remaining count is at or below the threshold, the FIFO is sampled. If it is still full, another frame carrying `pause_time_i` is sent, and this repeats for as long as the FIFO stays full.
- R6: If `rx_full_i` is low at the sampling point, a frame with pause time 0 is sent. No further FIFO-driven frame follows until the FIFO is full again.
- R7: `plt_sel_i` sets the threshold: 0 gives 4 quanta, 1 gives 28, 2 gives 144 and 3 gives 256.
- R8: No frame starts while `mac_busy_i` is high. A pending request waits and is sent once `mac_busy_i` falls.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_last_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fc_en_i | input | 1 | Transmit flow control enable |
| full_duplex_i | input | 1 | MAC is in full-duplex mode |
| pause_time_i | input | 16 | Programmed pause time in quanta |
| plt_sel_i | input | 2 | Low threshold select |
| src_addr_i | input | 48 | Station source address |
| sw_req_set_i | input | 1 | Software pause request pulse |
| sw_req_busy_o | output | 1 | Software request pending |
| rx_full_i | input | 1 | Receive FIFO full |
| quanta_tick_i | input | 1 | One pulse per 512 bit times |
| mac_busy_i | input | 1 | Transmitter busy with another frame |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Last byte of frame |
| tx_ready_i | input | 1 | Transmitter accepts byte |

## Verification
A corrupted byte index or a stale latched pause time shows up in the first frame, as a wrong byte or a misplaced `tx_last_o`. The byte-by-byte comparison catches it within 60 accepted bytes. A quanta counter that is off by one moves the refresh frame by exactly one tick, so the bench holds back one tick short of the sampling point and checks that nothing has started. A pause-tracking flag left in the wrong state shows up as a missing zero-time frame, or as a stray frame while the line stays quiet after the drain.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;
  localparam int TIME_W    = 16;
  localparam int ADDR_W    = 48;
  localparam int FRAME_LEN = 60;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {FP_NONE, FP_PAUSE, FP_ZERO} fifo_pend_e;

  function automatic logic [TIME_W-1:0] thr_quanta(input logic [1:0] sel);
    case (sel)
      2'd0:    thr_quanta = TIME_W'(4);
      2'd1:    thr_quanta = TIME_W'(28);
      2'd2:    thr_quanta = TIME_W'(144);
      default: thr_quanta = TIME_W'(256);
    endcase
  endfunction
endpackage

// File: rtl/pause_frame_tx.sv
module pause_frame_tx
  import pause_fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [7:0]        data_o,
  output logic              last_o,
  output logic              done_o,
  output logic [TIME_W-1:0] time_o
);
  logic [IDX_W-1:0]  idx_q;
  logic              act_q;
  logic [TIME_W-1:0] time_q;
  logic [ADDR_W-1:0] src_q;
  logic              hs;

  assign hs      = act_q & ready_i;
  assign last_o  = act_q & (idx_q == IDX_W'(FRAME_LEN-1));
  assign done_o  = hs & last_o;
  assign valid_o = act_q;
  assign busy_o  = act_q;
  assign time_o  = time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      time_q <= '0;
      src_q  <= '0;
    end else if (!act_q) begin
      if (start_i) begin
        act_q  <= 1'b1;
        idx_q  <= '0;
        time_q <= time_i;
        src_q  <= src_i;
      end
    end else if (hs) begin
      if (last_o) act_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    data_o = 8'h00;
    if (act_q) begin
      case (idx_q)
        IDX_W'(0):  data_o = 8'h01;
        IDX_W'(1):  data_o = 8'h80;
        IDX_W'(2):  data_o = 8'hC2;
        IDX_W'(5):  data_o = 8'h01;
        IDX_W'(6):  data_o = src_q[47:40];
        IDX_W'(7):  data_o = src_q[39:32];
        IDX_W'(8):  data_o = src_q[31:24];
        IDX_W'(9):  data_o = src_q[23:16];
        IDX_W'(10): data_o = src_q[15:8];
        IDX_W'(11): data_o = src_q[7:0];
        IDX_W'(12): data_o = 8'h88;
        IDX_W'(13): data_o = 8'h08;
        IDX_W'(15): data_o = 8'h01;
        IDX_W'(16): data_o = time_q[15:8];
        IDX_W'(17): data_o = time_q[7:0];
        default:    data_o = 8'h00;
      endcase
    end
  end

  p_hold_under_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));
  p_gap_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !valid_o);
endmodule

// File: rtl/pause_fifo_track.sv
module pause_fifo_track
  import pause_fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_full_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] thr_i,
  input  logic              done_i,
  input  logic              done_fifo_i,
  input  logic [TIME_W-1:0] done_time_i,
  output logic              req_o,
  output logic              zero_o
);
  fifo_pend_e        pend_q;
  logic              paused_q;
  logic [TIME_W-1:0] left_q;

  assign req_o  = pend_q != FP_NONE;
  assign zero_o = pend_q == FP_ZERO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (done_i) begin
      left_q <= done_time_i;
    end else if (tick_i && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= FP_NONE;
      paused_q <= 1'b0;
    end else if (!en_i) begin
      pend_q   <= FP_NONE;
      paused_q <= 1'b0;
    end else if (done_i && done_fifo_i) begin
      paused_q <= (pend_q == FP_PAUSE);
      pend_q   <= FP_NONE;
    end else if (pend_q == FP_NONE && !done_i) begin
      if (!paused_q) begin
        if (rx_full_i) pend_q <= FP_PAUSE;
      end else if (left_q <= thr_i) begin
        pend_q <= rx_full_i ? FP_PAUSE : FP_ZERO;
      end
    end
  end

  p_zero_only_when_drained_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == FP_ZERO && $past(pend_q) == FP_NONE) |-> !$past(rx_full_i));
  p_sample_at_threshold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(paused_q) && $past(pend_q) == FP_NONE && pend_q != FP_NONE) |-> $past(left_q <= thr_i));
endmodule

// File: rtl/pause_fc_gen.sv
module pause_fc_gen
  import pause_fc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fc_en_i,
  input  logic        full_duplex_i,
  input  logic [15:0] pause_time_i,
  input  logic [1:0]  plt_sel_i,
  input  logic [47:0] src_addr_i,
  input  logic        sw_req_set_i,
  output logic        sw_req_busy_o,
  input  logic        rx_full_i,
  input  logic        quanta_tick_i,
  input  logic        mac_busy_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i
);
  logic              gate, start, tx_busy, done, fifo_req, fifo_zero;
  logic              sw_q, cur_sw_q;
  logic [TIME_W-1:0] start_time, sent_time;

  assign gate       = fc_en_i & full_duplex_i;
  assign start      = gate & ~tx_busy & ~mac_busy_i & (sw_q | fifo_req);
  // software request wins arbitration; FIFO request stays pending
  assign start_time = (!sw_q && fifo_zero) ? '0 : pause_time_i;
  assign sw_req_busy_o = sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q     <= 1'b0;
      cur_sw_q <= 1'b0;
    end else begin
      if (start) cur_sw_q <= sw_q;
      if (sw_req_set_i && gate) sw_q <= 1'b1;
      else if (done && cur_sw_q) sw_q <= 1'b0;
    end
  end

  pause_frame_tx i_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .time_i  (start_time),
    .src_i   (src_addr_i),
    .ready_i (tx_ready_i),
    .busy_o  (tx_busy),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o),
    .last_o  (tx_last_o),
    .done_o  (done),
    .time_o  (sent_time)
  );

  pause_fifo_track i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (gate),
    .rx_full_i   (rx_full_i),
    .tick_i      (quanta_tick_i),
    .thr_i       (thr_quanta(plt_sel_i)),
    .done_i      (done),
    .done_fifo_i (~cur_sw_q),
    .done_time_i (sent_time),
    .req_o       (fifo_req),
    .zero_o      (fifo_zero)
  );

  p_start_needs_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(gate));
  p_no_midframe_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> !$past(mac_busy_i));
  p_busy_clears_on_handover_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_req_busy_o) |-> $past(tx_last_o && tx_valid_o && tx_ready_i));
endmodule

// File: tb/test_pause_fc_gen.sv
module test_pause_fc_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fc_en = 1'b0, fdx = 1'b0, sw_set = 1'b0, rx_full = 1'b0;
  logic        tick = 1'b0, mac_busy = 1'b0, tx_ready = 1'b0;
  logic [15:0] ptime = 16'd0;
  logic [1:0]  plt = 2'd0;
  logic [47:0] src = 48'h0;
  logic        sw_busy, tx_valid, tx_last;
  logic [7:0]  tx_data;
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_fc_gen i_pause_fc_gen (
    .clk_i(clk), .rst_ni(rst_n), .fc_en_i(fc_en), .full_duplex_i(fdx),
    .pause_time_i(ptime), .plt_sel_i(plt), .src_addr_i(src),
    .sw_req_set_i(sw_set), .sw_req_busy_o(sw_busy), .rx_full_i(rx_full),
    .quanta_tick_i(tick), .mac_busy_i(mac_busy), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  function automatic logic [7:0] exp_byte(int i, logic [15:0] t, logic [47:0] sa);
    logic [7:0] da [6] = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
    if (i < 6)   return da[i];
    if (i < 12)  return sa[8*(11-i) +: 8];
    if (i == 12) return 8'h88;
    if (i == 13) return 8'h08;
    if (i == 15) return 8'h01;
    if (i == 16) return t[15:8];
    if (i == 17) return t[7:0];
    return 8'h00;
  endfunction

  function automatic int thr_of(logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 28;
      2'd2: return 144;
      default: return 256;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_set = 1'b1;
    @(negedge clk); sw_set = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tx_valid) seen++;
    end
    check(seen == 0, req, "unexpected frame activity", seen, 0);
  endtask

  // collects one frame with random backpressure and compares every byte (R3, R9)
  task automatic get_frame(logic [15:0] t, string req);
    int waited = 0, bad = 0, stall_bad = 0;
    bit held = 0;
    logic [8:0] hold_v = '0;
    while (!tx_valid && waited < 300) begin @(negedge clk); waited++; end
    check(tx_valid, req, "frame start", tx_valid, 1);
    if (!tx_valid) return;
    for (int i = 0; i < 60;) begin
      tx_ready = ($urandom % 4) != 0;
      if (held && {tx_last, tx_data} != hold_v) stall_bad++;
      if (!tx_valid) begin bad++; i = 60; end
      else if (tx_ready) begin
        if (tx_data != exp_byte(i, t, src) || tx_last != (i == 59)) begin
          bad++;
          $display("FAIL R3 byte %0d: actual %0h/%0b expected %0h/%0b",
                   i, tx_data, tx_last, exp_byte(i, t, src), i == 59);
        end
        held = 0; i++;
      end else begin
        held = 1; hold_v = {tx_last, tx_data};
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    n_cmp++; if (bad != 0) n_bad++;
    if (bad != 0) $display("FAIL %s frame content: actual %0d bad bytes expected 0 (time %0h)", req, bad, t);
    check(stall_bad == 0, "R9", "data held under stall", stall_bad, 0);
    check(!tx_valid, "R3", "valid low after byte 59", tx_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_junk;
    logic [15:0] t;
    seed_junk = $urandom(32'h5eed);
    src = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    check(!tx_valid && !sw_busy, "R2", "reset outputs", {tx_valid, sw_busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: gating
    fc_en = 1'b0; fdx = 1'b1; ptime = 16'h1234;
    pulse_sw();
    check(!sw_busy, "R1", "request dropped while disabled", sw_busy, 0);
    quiet(20, "R1");
    fc_en = 1'b1; fdx = 1'b0; rx_full = 1'b1;
    quiet(20, "R1");
    rx_full = 1'b0; fdx = 1'b1;
    quiet(5, "R1");

    // R2/R3: software requests with random times
    for (int k = 0; k < 5; k++) begin
      t = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : 16'($urandom);
      ptime = t;
      src = {$urandom, $urandom};
      pulse_sw();
      check(sw_busy, "R2", "busy after request", sw_busy, 1);
      get_frame(t, "R2");
      @(negedge clk);
      check(!sw_busy, "R2", "busy cleared after handover", sw_busy, 0);
      quiet(30, "R2");
    end

    // R8: wait for transmitter
    mac_busy = 1'b1; ptime = 16'h0A0B;
    pulse_sw();
    quiet(25, "R8");
    mac_busy = 1'b0;
    get_frame(16'h0A0B, "R8");
    quiet(10, "R8");

    // R4-R7: FIFO-driven pauses for each threshold
    for (int s = 0; s < 4; s++) begin
      int thr, p;
      plt = 2'(s);
      thr = thr_of(plt);
      p = thr + 2 + int'($urandom % 4);
      ptime = 16'(p);
      rx_full = 1'b1;
      get_frame(16'(p), "R4");
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < p - thr - 1; k++) pulse_tick();
        quiet(10, "R7");
        pulse_tick();
        get_frame(16'(p), "R5");
      end
      rx_full = 1'b0;
      for (int k = 0; k < p - thr - 1; k++) pulse_tick();
      quiet(10, "R6");
      pulse_tick();
      get_frame(16'h0000, "R6");
      for (int k = 0; k < 12; k++) pulse_tick();
      quiet(20, "R6");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule